// File: doc/BRIEF.md
# Processor INIT Pulse Generator

This block produces the active-low initialization pulse sent to the processor. Four legacy sources can fire it: a shutdown special cycle, a write to the fast-reset port (0x92), a write to the reset-control port (0xCF9), and a low level on the keyboard controller's reset request. The block keeps the control bits it needs from both ports, so it can tell a real 0-to-1 change from a repeated write.

After an accepted trigger, the INIT line goes low for a fixed number of bus clocks and is then released. While the active-low clock-stop request is asserted, the pulse counter does not advance. A trigger that arrives during clock-stop is held and starts its pulse only after clock-stop is released. A second INIT output carries the same waveform. A self-test flag is driven out while a self-test reset pulse is running.

There is no streaming data path. Every pin is a plain level or a one-cycle strobe. The block has no valid/ready handshake and applies no back-pressure: a write strobe is always taken in the cycle it is high.

Top module: `init_pulse_gen`

## Requirements
- R1: After an accepted trigger in cycle t, `init_n_o` is low from cycle t+1 for exactly PULSE_LEN (default 16) cycles while clock-stop stays deasserted. It then returns high.
- R2: While `clk_stop_n_i` is low, the pulse count does not advance and INIT stays at its current level. A trigger seen during clock-stop starts its pulse in the cycle after `clk_stop_n_i` returns high.
- R3: A one-cycle high on `shutdown_i` triggers INIT.
- R4: A write strobe on `fast_wr_i` triggers INIT only when data bit 0 is 1 and the stored bit 0 is 0. Every write stores data bit 0, and the stored bit starts at 0 after reset.
- R5: A write strobe on `rstctl_wr_i` triggers INIT only when data bit 1 is 0, data bit 2 is 1, and the stored bit 2 is 0. Every write stores data bit 2.
- R6: A low level on `kbc_rst_n_i` triggers INIT once. That source cannot fire again until the input has been seen high.
- R7: When `slp_state_i` is DEEP_LEVEL (default 3) or higher, a low level on `kbc_rst_n_i` does not trigger INIT.
- R8: When a reset-control write fires INIT with `selftest_en_i` high, `selftest_o` is high for every cycle of that pulse. At all other times it is low.
- R9: `init2_n_o` has the same value as `init_n_o` in every cycle.
- R10: A trigger that arrives while a pulse is active or waiting is dropped. The pulse then ends PULSE_LEN run-cycles after its own start.
- R11: While `rst_n` is low at a clock edge, the next state has both INIT outputs high, `selftest_o` low, the stored port bits at 0, and the keyboard source armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shutdown_i | input | 1 | Shutdown special-cycle strobe |
| fast_wr_i | input | 1 | Write strobe, port 0x92 |
| fast_wdata_i | input | 8 | Write data, port 0x92 |
| rstctl_wr_i | input | 1 | Write strobe, port 0xCF9 |
| rstctl_wdata_i | input | 8 | Write data, port 0xCF9 |
| kbc_rst_n_i | input | 1 | Keyboard controller reset request, active low |
| clk_stop_n_i | input | 1 | Clock-stop request, active low |
| slp_state_i | input | 3 | Current sleep level |
| selftest_en_i | input | 1 | Processor self-test enable bit |
| init_n_o | output | 1 | INIT to processor, active low |
| init2_n_o | output | 1 | Second INIT output, same waveform |
| selftest_o | output | 1 | Self-test request, valid while INIT is low |

## Verification
Two functions can land on the same clock edge: the pulse counter freezing and a new trigger being accepted. Clock-stop can also fall partway through a running pulse. The bench raises clock-stop before a shutdown strobe and checks that INIT stays high until the release, then lasts 16 cycles. It also stalls a pulse already under way and checks that the low time grows by exactly the stalled cycles. A further case fires a second source in the middle of a pulse; the low time must still be 16 with no restart.

// File: rtl/init_pulse_pkg.sv
package init_pulse_pkg;
  typedef struct packed {
    logic shutdown;
    logic fast;
    logic rstctl;
    logic kbc;
  } trig_src_t;
endpackage

// File: rtl/init_port_regs.sv
module init_port_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_wr_i,
  input  logic [7:0] fast_wdata_i,
  input  logic       rstctl_wr_i,
  input  logic [7:0] rstctl_wdata_i,
  output logic       fast_trig_o,
  output logic       rstctl_trig_o
);
  logic fast_bit_q;
  logic cpurst_bit_q;

  assign fast_trig_o   = fast_wr_i && fast_wdata_i[0] && !fast_bit_q;
  assign rstctl_trig_o = rstctl_wr_i && !rstctl_wdata_i[1] && rstctl_wdata_i[2] && !cpurst_bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_bit_q   <= 1'b0;
      cpurst_bit_q <= 1'b0;
    end else begin
      if (fast_wr_i)   fast_bit_q   <= fast_wdata_i[0];
      if (rstctl_wr_i) cpurst_bit_q <= rstctl_wdata_i[2];
    end
  end

  AST_FAST_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    fast_trig_o |=> fast_bit_q); // R4
  AST_CPURST_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    rstctl_trig_o |=> cpurst_bit_q); // R5
endmodule

// File: rtl/init_kbc_arm.sv
module init_kbc_arm #(
  parameter int SLP_W      = 3,
  parameter int DEEP_LEVEL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kbc_rst_n_i,
  input  logic [SLP_W-1:0] slp_state_i,
  output logic             kbc_trig_o
);
  logic armed_q;
  logic deep;

  assign deep       = (slp_state_i >= SLP_W'(DEEP_LEVEL));
  assign kbc_trig_o = armed_q && !kbc_rst_n_i && !deep;

  always_ff @(posedge clk) begin
    if (!rst_n)           armed_q <= 1'b1;
    else if (kbc_rst_n_i) armed_q <= 1'b1;
    else if (kbc_trig_o)  armed_q <= 1'b0;
  end

  AST_KBC_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    kbc_trig_o |=> !armed_q); // R6
  AST_KBC_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
    deep |-> !kbc_trig_o); // R7
endmodule

// File: rtl/init_pulse_timer.sv
module init_pulse_timer #(
  parameter int PULSE_LEN = 16,
  localparam int CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic st_req_i,
  input  logic clk_stop_n_i,
  output logic active_o,
  output logic st_active_o
);
  logic          active_q;
  logic          pend_q;
  logic          st_q;
  logic [CW-1:0] cnt_q;
  logic          run;
  logic          last;

  assign run  = clk_stop_n_i;
  assign last = (cnt_q == CW'(PULSE_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      st_q     <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (run) begin
        if (last) begin
          active_q <= 1'b0;
          st_q     <= 1'b0;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else if (pend_q) begin
      if (run) begin
        pend_q   <= 1'b0;
        active_q <= 1'b1;
      end
    end else if (trig_i) begin
      st_q <= st_req_i;
      if (run) active_q <= 1'b1;
      else     pend_q   <= 1'b1;
    end
  end

  assign active_o    = active_q;
  assign st_active_o = active_q && st_q;

  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !last |=> active_q); // R1
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !run |=> active_q && $stable(cnt_q)); // R2
  AST_STOP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q && !run |=> !active_q); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && trig_i && run && !last |=> cnt_q == $past(cnt_q) + 1'b1); // R10
endmodule

// File: rtl/init_pulse_gen.sv
module init_pulse_gen #(
  parameter int PULSE_LEN  = 16,
  parameter int SLP_W      = 3,
  parameter int DEEP_LEVEL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shutdown_i,
  input  logic             fast_wr_i,
  input  logic [7:0]       fast_wdata_i,
  input  logic             rstctl_wr_i,
  input  logic [7:0]       rstctl_wdata_i,
  input  logic             kbc_rst_n_i,
  input  logic             clk_stop_n_i,
  input  logic [SLP_W-1:0] slp_state_i,
  input  logic             selftest_en_i,
  output logic             init_n_o,
  output logic             init2_n_o,
  output logic             selftest_o
);
  import init_pulse_pkg::*;

  trig_src_t src;
  logic      any_trig;
  logic      active;

  assign src.shutdown = shutdown_i;

  init_port_regs u_ports (
    .clk            (clk),
    .rst_n          (rst_n),
    .fast_wr_i      (fast_wr_i),
    .fast_wdata_i   (fast_wdata_i),
    .rstctl_wr_i    (rstctl_wr_i),
    .rstctl_wdata_i (rstctl_wdata_i),
    .fast_trig_o    (src.fast),
    .rstctl_trig_o  (src.rstctl)
  );

  init_kbc_arm #(.SLP_W(SLP_W), .DEEP_LEVEL(DEEP_LEVEL)) u_kbc (
    .clk         (clk),
    .rst_n       (rst_n),
    .kbc_rst_n_i (kbc_rst_n_i),
    .slp_state_i (slp_state_i),
    .kbc_trig_o  (src.kbc)
  );

  assign any_trig = |src;

  init_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (any_trig),
    .st_req_i     (src.rstctl && selftest_en_i),
    .clk_stop_n_i (clk_stop_n_i),
    .active_o     (active),
    .st_active_o  (selftest_o)
  );

  assign init_n_o  = !active;
  assign init2_n_o = !active;

  AST_SELFTEST_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    selftest_o |-> !init_n_o); // R8
  AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    init_n_o == init2_n_o); // R9
  AST_SHUTDOWN_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i && init_n_o && clk_stop_n_i |=> !init_n_o); // R3
endmodule

// File: tb/tb_init_pulse_gen.sv
module tb_init_pulse_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       shutdown_i, fast_wr_i, rstctl_wr_i;
  logic [7:0] fast_wdata_i, rstctl_wdata_i;
  logic       kbc_rst_n_i, clk_stop_n_i, selftest_en_i;
  logic [2:0] slp_state_i;
  logic       init_n_o, init2_n_o, selftest_o;

  int checks = 0;
  int fails  = 0;
  int lowc, sthi, mism;

  always #4 clk = ~clk;

  init_pulse_gen dut (
    .clk(clk), .rst_n(rst_n), .shutdown_i(shutdown_i),
    .fast_wr_i(fast_wr_i), .fast_wdata_i(fast_wdata_i),
    .rstctl_wr_i(rstctl_wr_i), .rstctl_wdata_i(rstctl_wdata_i),
    .kbc_rst_n_i(kbc_rst_n_i), .clk_stop_n_i(clk_stop_n_i),
    .slp_state_i(slp_state_i), .selftest_en_i(selftest_en_i),
    .init_n_o(init_n_o), .init2_n_o(init2_n_o), .selftest_o(selftest_o)
  );

  // vector: {kind[1:0], data[7:0], expect_fire}; kind 0=port 0x92, 1=port 0xCF9, 2=shutdown
  localparam logic [10:0] VEC [12] = '{
    {2'd0, 8'h01, 1'b1},  // R4 rise
    {2'd0, 8'h01, 1'b0},  // R4 already 1
    {2'd0, 8'h00, 1'b0},  // R4 clear
    {2'd0, 8'h01, 1'b1},  // R4 rise again
    {2'd1, 8'h04, 1'b1},  // R5 cpu reset rise
    {2'd1, 8'h04, 1'b0},  // R5 already 1
    {2'd1, 8'h00, 1'b0},  // R5 clear
    {2'd1, 8'h06, 1'b0},  // R5 system reset bit blocks
    {2'd1, 8'h00, 1'b0},  // R5 clear
    {2'd1, 8'h04, 1'b1},  // R5 fire
    {2'd2, 8'h00, 1'b1},  // R3 shutdown
    {2'd1, 8'h02, 1'b0}   // R5 bit2 zero
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int n);
    lowc = 0; sthi = 0; mism = 0;
    for (int i = 0; i < n; i++) begin
      if (!init_n_o) lowc++;
      if (selftest_o) sthi++;
      if (init_n_o != init2_n_o) mism++;
      @(negedge clk);
    end
  endtask

  task automatic apply(input logic [1:0] kind, input logic [7:0] d);
    @(negedge clk);
    case (kind)
      2'd0: begin fast_wr_i = 1'b1; fast_wdata_i = d; end
      2'd1: begin rstctl_wr_i = 1'b1; rstctl_wdata_i = d; end
      default: shutdown_i = 1'b1;
    endcase
    @(negedge clk);
    fast_wr_i = 1'b0; rstctl_wr_i = 1'b0; shutdown_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; shutdown_i = 0; fast_wr_i = 0; rstctl_wr_i = 0;
    fast_wdata_i = 0; rstctl_wdata_i = 0; kbc_rst_n_i = 1;
    clk_stop_n_i = 1; slp_state_i = 0; selftest_en_i = 0;
    do_reset();
    @(negedge clk);
    check("R11 init_n after reset", init_n_o, 1);
    check("R11 selftest after reset", selftest_o, 0);

    for (int v = 0; v < 12; v++) begin
      apply(VEC[v][10:9], VEC[v][8:1]);
      measure(24);
      check($sformatf("R1 vec%0d low cycles", v), lowc, VEC[v][0] ? 16 : 0);
      check("R9 lockstep", mism, 0);
    end

    // R6 keyboard source: fire once, stay disarmed while low, rearm on high
    @(negedge clk); kbc_rst_n_i = 1'b0;
    @(negedge clk);
    measure(40);
    check("R6 kbc first fire", lowc, 16);
    kbc_rst_n_i = 1'b1;
    @(negedge clk); kbc_rst_n_i = 1'b0;
    @(negedge clk);
    measure(24);
    check("R6 kbc rearmed fire", lowc, 16);
    kbc_rst_n_i = 1'b1;

    // R7 deep sleep ignores keyboard source
    slp_state_i = 3'd3;
    @(negedge clk); kbc_rst_n_i = 1'b0;
    @(negedge clk);
    measure(24);
    check("R7 kbc in deep sleep", lowc, 0);
    kbc_rst_n_i = 1'b1; slp_state_i = 3'd0;
    @(negedge clk);

    // R2 trigger during clock-stop waits
    clk_stop_n_i = 1'b0;
    apply(2'd2, 8'h00);
    measure(10);
    check("R2 held during stop", lowc, 0);
    clk_stop_n_i = 1'b1;
    @(negedge clk);
    check("R2 starts after release", init_n_o, 0);
    measure(24);
    check("R2 deferred length", lowc, 16);

    // R2 stall in mid pulse lengthens by stalled cycles
    apply(2'd2, 8'h00);
    measure(5);
    clk_stop_n_i = 1'b0;
    measure(7);
    clk_stop_n_i = 1'b1;
    check("R2 low during stall", lowc, 7);
    measure(20);
    check("R2 remaining after stall", lowc, 11);

    // R10 trigger during active pulse dropped
    apply(2'd2, 8'h00);
    measure(3);
    shutdown_i = 1'b1;
    @(negedge clk);
    shutdown_i = 1'b0;
    measure(30);
    check("R10 no restart", lowc, 12);

    // R8 self-test flag
    apply(2'd1, 8'h00);
    selftest_en_i = 1'b1;
    apply(2'd1, 8'h04);
    measure(24);
    check("R8 selftest high cycles", sthi, 16);
    check("R8 pulse length", lowc, 16);
    selftest_en_i = 1'b1;
    apply(2'd2, 8'h00);
    measure(24);
    check("R8 no selftest on shutdown", sthi, 0);
    selftest_en_i = 1'b0;

    // R11 reset clears stored bits: port 0x92 fires again after reset
    apply(2'd0, 8'h01);
    measure(24);
    check("R4 stored one blocks", lowc, 0);
    do_reset();
    @(negedge clk);
    check("R11 init high after reset", init_n_o, 1);
    apply(2'd0, 8'h01);
    measure(24);
    check("R11 stored bit cleared", lowc, 16);

    // R11 reset during pulse releases INIT
    apply(2'd2, 8'h00);
    measure(3);
    do_reset();
    @(negedge clk);
    check("R11 reset ends pulse", init_n_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule